// File: doc/BRIEF.md
# LCD Driver Command Byte Decoder

This block sits behind the byte receiver of a serial control bus on an LCD segment driver. The receiver has already handled framing, acknowledge and address matching. It hands over each received byte with a byte-valid strobe, and it marks the start of every transfer with a start strobe. The decoder decides whether each byte is a command or display data. It latches the command fields into configuration registers, and it turns display data into RAM write requests.

Bit 7 of every command byte is a continuation flag. When the flag is 1, the next byte is another command. When it is 0, every later byte of the transfer is display data. The command type is set by a prefix code of varying length in bits 6 down to 2. The command types are:

- mode set: power mode, display enable, bias and drive mode
- load data pointer
- device subaddress select
- input and output bank select
- blink setting

In the data phase, each byte is written at the current pointer address, and the pointer then advances with wrap-around. The write happens only when the latched subaddress matches the hardware subaddress pins.

Top module: `lcdcmd_decoder`

## Requirements
- R1: The first byte after a start strobe is a command, including a byte that arrives in the same cycle as the strobe. A command byte with bit 7 = 1 makes the next byte a command. A command byte with bit 7 = 0 makes every later byte of the transfer display data, whatever its bit pattern.
- R2: A command with bits 6:5 = 10 (mode set) loads four fields, all visible the cycle after the byte: low_power from bit 4, disp_en from bit 3, bias_sel from bit 2 and drive_mode from bits 1:0.
- R3: bp_count shows the number of backplanes for the drive mode: drive_mode 01 gives 1, 10 gives 2, 11 gives 3 and 00 gives 4.
- R4: A command with bit 6 = 0 loads the data pointer with bits 5:0 reduced modulo 24, so 63 becomes 15.
- R5: A command with bits 6:3 = 1100 loads dev_subaddr from bits 2:0.
- R6: A command with bits 6:2 = 11110 loads bank_in_sel from bit 1 and bank_out_sel from bit 0.
- R7: A command with bits 6:3 = 1110 loads blink_alt from bit 2 and blink_freq from bits 1:0.
- R8: A command with bits 6:3 = 1101 or bits 6:2 = 11111 changes no register, but its bit 7 still decides the phase of the next byte.
- R9: A data byte gives a one-cycle wr_en pulse in the cycle after the byte. The pulse carries wr_addr equal to the pointer, wr_data equal to the byte and wr_bank equal to bank_in_sel. The pointer then increments and wraps from 23 to 0.
- R10: A data byte is written only when dev_subaddr equals hw_subaddr. The pointer advances whether or not the write happens.
- R11: Reset (synchronous, active high) sets every output to zero except bp_count, which reads 4. This gives display disabled, drive_mode 00 (1:4), pointer 0, subaddress 0, bank 0 and blink off.
- R12: The configuration outputs change only in the cycle after a command byte. Display data bytes and idle cycles leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | Start-of-transfer strobe |
| byte_vld | input | 1 | byte_in holds a received byte |
| byte_in | input | 8 | Received byte |
| hw_subaddr | input | 3 | Hardware subaddress pins |
| low_power | output | 1 | Power mode from mode set |
| disp_en | output | 1 | Display enable |
| bias_sel | output | 1 | Bias select |
| drive_mode | output | 2 | Raw drive mode code |
| bp_count | output | 3 | Backplane count decoded from drive_mode |
| dev_subaddr | output | 3 | Latched device subaddress |
| bank_in_sel | output | 1 | Bank that receives display data |
| bank_out_sel | output | 1 | Bank read out for display |
| blink_alt | output | 1 | Blink mode select |
| blink_freq | output | 2 | Blink frequency code, 0 = off |
| wr_en | output | 1 | Display RAM write strobe |
| wr_addr | output | 5 | Display RAM write address |
| wr_data | output | 8 | Display RAM write data |
| wr_bank | output | 1 | Bank for this write |

## Verification
The assertions check the following on every cycle:

- the pointer always stays below 24
- after each write, the pointer sits one past the written address, with wrap-around
- writes happen only after a received byte, and only when the subaddresses matched
- configuration never changes after a cycle with no command byte

The bench scenarios cover the behaviour that depends on meaning rather than on cycle-level invariants:

- how each prefix code is classified, and the field positions inside each command
- the modulo reduction of a loaded pointer
- reserved codes that still steer the phase
- a data byte whose pattern looks like a command and must not act as one

// File: rtl/lcdcmd_pkg.sv
package lcdcmd_pkg;

    localparam int BYTE_W  = 8;
    localparam int SUB_W   = 3;
    localparam int FIELD_W = 6;

    typedef enum logic [2:0] {
        K_PTR,
        K_MODE,
        K_DEVSEL,
        K_BANK,
        K_BLINK,
        K_RSVD
    } cmd_kind_e;

    // Packed order matches the bit positions of the mode-set byte (4..0).
    typedef struct packed {
        logic       low_power;
        logic       disp_en;
        logic       bias;
        logic [1:0] drive;
    } mode_cfg_t;

    typedef struct packed {
        logic in_sel;
        logic out_sel;
    } bank_cfg_t;

    typedef struct packed {
        logic       alt_mode;
        logic [1:0] freq;
    } blink_cfg_t;

    typedef struct packed {
        logic                 cont;
        cmd_kind_e            kind;
        logic [FIELD_W-1:0]   arg;
    } cmd_word_t;

    // Prefix-code classification of bits 6:0 of a command byte.
    function automatic cmd_kind_e kind_of(input logic [6:0] f);
        if (!f[6])              return K_PTR;
        if (!f[5])              return K_MODE;
        if (f[4:3] == 2'b00)    return K_DEVSEL;
        if (f[4:3] == 2'b10)    return K_BLINK;
        if (f[4:2] == 3'b110)   return K_BANK;
        return K_RSVD;
    endfunction

    function automatic cmd_word_t split_byte(input logic [BYTE_W-1:0] b);
        cmd_word_t w;
        w.cont = b[7];
        w.kind = kind_of(b[6:0]);
        w.arg  = b[FIELD_W-1:0];
        return w;
    endfunction

    function automatic logic [2:0] backplanes(input logic [1:0] drive);
        case (drive)
            2'b01:   return 3'd1;
            2'b10:   return 3'd2;
            2'b11:   return 3'd3;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lcdcmd_phase_ctrl.sv
module lcdcmd_phase_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic xfer_start,
    input  logic byte_vld,
    input  logic cont_bit,
    output logic is_cmd,
    output logic is_data
);
    // Set when the next byte to arrive is to be taken as a command.
    logic cmd_next_q;

    always_comb begin
        is_cmd  = byte_vld & (xfer_start | cmd_next_q);
        is_data = byte_vld & ~xfer_start & ~cmd_next_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_next_q <= 1'b1;
        end else if (is_cmd) begin
            cmd_next_q <= cont_bit;
        end else if (xfer_start) begin
            cmd_next_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lcdcmd_cfg_regs.sv
module lcdcmd_cfg_regs
    import lcdcmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_stb,
    input  cmd_word_t           cmd,
    output mode_cfg_t           mode,
    output logic [SUB_W-1:0]    subaddr,
    output bank_cfg_t           bank,
    output blink_cfg_t          blink,
    output logic                ptr_load,
    output logic [FIELD_W-1:0]  ptr_val
);
    mode_cfg_t          mode_q;
    logic [SUB_W-1:0]   sub_q;
    bank_cfg_t          bank_q;
    blink_cfg_t         blink_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            sub_q   <= '0;
            bank_q  <= '0;
            blink_q <= '0;
        end else if (cmd_stb) begin
            case (cmd.kind)
                K_MODE:   mode_q  <= mode_cfg_t'(cmd.arg[4:0]);
                K_DEVSEL: sub_q   <= cmd.arg[SUB_W-1:0];
                K_BANK:   bank_q  <= bank_cfg_t'(cmd.arg[1:0]);
                K_BLINK:  blink_q <= blink_cfg_t'(cmd.arg[2:0]);
                default:  ;
            endcase
        end
    end

    always_comb begin
        mode     = mode_q;
        subaddr  = sub_q;
        bank     = bank_q;
        blink    = blink_q;
        ptr_load = cmd_stb && (cmd.kind == K_PTR);
        ptr_val  = cmd.arg;
    end
endmodule

// File: rtl/lcdcmd_wr_path.sv
module lcdcmd_wr_path
    import lcdcmd_pkg::*;
#(
    parameter  int NUM_ADDR = 24,
    localparam int ADDR_W   = $clog2(NUM_ADDR)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ptr_load,
    input  logic [FIELD_W-1:0]  ptr_val,
    input  logic                data_stb,
    input  logic [BYTE_W-1:0]   data_in,
    input  logic [SUB_W-1:0]    dev_sub,
    input  logic [SUB_W-1:0]    hw_sub,
    input  logic                bank_sel,
    output logic [ADDR_W-1:0]   ptr,
    output logic                wr_en,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                wr_bank
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_ADDR - 1);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] load_val;
    logic [ADDR_W-1:0] ptr_inc;
    logic              wr_hit;

    always_comb begin
        load_val = ADDR_W'(32'(ptr_val) % 32'(NUM_ADDR));
        ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        wr_hit   = data_stb && (dev_sub == hw_sub);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_bank <= 1'b0;
        end else begin
            wr_en <= wr_hit;
            if (wr_hit) begin
                wr_addr <= ptr_q;
                wr_data <= data_in;
                wr_bank <= bank_sel;
            end
            if (ptr_load) begin
                ptr_q <= load_val;
            end else if (data_stb) begin
                ptr_q <= ptr_inc;
            end
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/lcdcmd_decoder.sv
module lcdcmd_decoder
    import lcdcmd_pkg::*;
#(
    parameter  int NUM_ADDR = 24,
    localparam int ADDR_W   = $clog2(NUM_ADDR)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xfer_start,
    input  logic              byte_vld,
    input  logic [7:0]        byte_in,
    input  logic [2:0]        hw_subaddr,
    output logic              low_power,
    output logic              disp_en,
    output logic              bias_sel,
    output logic [1:0]        drive_mode,
    output logic [2:0]        bp_count,
    output logic [2:0]        dev_subaddr,
    output logic              bank_in_sel,
    output logic              bank_out_sel,
    output logic              blink_alt,
    output logic [1:0]        blink_freq,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_bank
);
    cmd_word_t          cmd;
    logic               is_cmd;
    logic               is_data;
    mode_cfg_t          mode;
    bank_cfg_t          bank;
    blink_cfg_t         blink;
    logic               ptr_load;
    logic [FIELD_W-1:0] ptr_val;
    logic [ADDR_W-1:0]  ptr_q;

    assign cmd = split_byte(byte_in);

    lcdcmd_phase_ctrl u_phase (
        .clk        (clk),
        .rst        (rst),
        .xfer_start (xfer_start),
        .byte_vld   (byte_vld),
        .cont_bit   (cmd.cont),
        .is_cmd     (is_cmd),
        .is_data    (is_data)
    );

    lcdcmd_cfg_regs u_cfg (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (is_cmd),
        .cmd      (cmd),
        .mode     (mode),
        .subaddr  (dev_subaddr),
        .bank     (bank),
        .blink    (blink),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val)
    );

    lcdcmd_wr_path #(.NUM_ADDR(NUM_ADDR)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .ptr_load (ptr_load),
        .ptr_val  (ptr_val),
        .data_stb (is_data),
        .data_in  (byte_in),
        .dev_sub  (dev_subaddr),
        .hw_sub   (hw_subaddr),
        .bank_sel (bank.in_sel),
        .ptr      (ptr_q),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_bank  (wr_bank)
    );

    always_comb begin
        low_power    = mode.low_power;
        disp_en      = mode.disp_en;
        bias_sel     = mode.bias;
        drive_mode   = mode.drive;
        bp_count     = backplanes(mode.drive);
        bank_in_sel  = bank.in_sel;
        bank_out_sel = bank.out_sel;
        blink_alt    = blink.alt_mode;
        blink_freq   = blink.freq;
    end
endmodule

// File: rtl/lcdcmd_decoder_chk.sv
module lcdcmd_decoder_chk #(
    parameter  int NUM_ADDR = 24,
    localparam int ADDR_W   = $clog2(NUM_ADDR)
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_vld,
    input logic              is_cmd,
    input logic [2:0]        hw_subaddr,
    input logic [2:0]        dev_subaddr,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [15:0]       cfg_vec
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_ADDR - 1);

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= LAST);

    // R9
    ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> ptr_q == ((wr_addr == LAST) ? '0 : wr_addr + 1'b1));

    // R9
    wr_source_chk: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> !wr_en);

    // R10
    wr_match_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(dev_subaddr) == $past(hw_subaddr));

    // R12
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !is_cmd |=> $stable(cfg_vec));
endmodule

bind lcdcmd_decoder lcdcmd_decoder_chk #(.NUM_ADDR(NUM_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .byte_vld    (byte_vld),
    .is_cmd      (is_cmd),
    .hw_subaddr  (hw_subaddr),
    .dev_subaddr (dev_subaddr),
    .ptr_q       (ptr_q),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .cfg_vec     ({low_power, disp_en, bias_sel, drive_mode, dev_subaddr,
                   bank_in_sel, bank_out_sel, blink_alt, blink_freq, 3'b000})
);

// File: tb/lcdcmd_decoder_bench.sv
module lcdcmd_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NADDR      = 24;
    localparam int WD_CYCLES  = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic [2:0] hw_subaddr = '0;
    logic       low_power, disp_en, bias_sel, bank_in_sel, bank_out_sel, blink_alt;
    logic [1:0] drive_mode, blink_freq;
    logic [2:0] bp_count, dev_subaddr;
    logic       wr_en, wr_bank;
    logic [4:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [4:0] addr;
        logic [7:0] data;
        logic       bank;
    } wr_item_t;

    wr_item_t exp_q[$];

    // Model state built from the requirements.
    int   m_ptr  = 0;
    int   m_sub  = 0;
    logic m_bank = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcdcmd_decoder u_lcdcmd_decoder (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .hw_subaddr(hw_subaddr), .low_power(low_power),
        .disp_en(disp_en), .bias_sel(bias_sel), .drive_mode(drive_mode),
        .bp_count(bp_count), .dev_subaddr(dev_subaddr), .bank_in_sel(bank_in_sel),
        .bank_out_sel(bank_out_sel), .blink_alt(blink_alt), .blink_freq(blink_freq),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_bank(wr_bank)
    );

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    // Drives one byte; on return the registered response is visible.
    task automatic send_byte(input logic [7:0] b, input logic with_start);
        @(negedge clk);
        byte_in    = b;
        byte_vld   = 1'b1;
        xfer_start = with_start;
        @(negedge clk);
        byte_vld   = 1'b0;
        xfer_start = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] b);
        if (m_sub == int'(hw_subaddr))
            exp_q.push_back('{addr: 5'(m_ptr), data: b, bank: m_bank});
        m_ptr = (m_ptr + 1) % NADDR;
        send_byte(b, 1'b0);
    endtask

    task automatic check_cfg(input string req, input int lp, input int en, input int bs,
                             input int dm, input int sub, input int bi, input int bo,
                             input int ba, input int bf);
        check(req, "low_power", int'(low_power), lp);
        check(req, "disp_en", int'(disp_en), en);
        check(req, "bias_sel", int'(bias_sel), bs);
        check(req, "drive_mode", int'(drive_mode), dm);
        check(req, "dev_subaddr", int'(dev_subaddr), sub);
        check(req, "bank_in_sel", int'(bank_in_sel), bi);
        check(req, "bank_out_sel", int'(bank_out_sel), bo);
        check(req, "blink_alt", int'(blink_alt), ba);
        check(req, "blink_freq", int'(blink_freq), bf);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Scoreboard monitor: each write pops the oldest expected item.
    always @(negedge clk) begin
        if (!rst && wr_en) begin
            if (exp_q.size() == 0) begin
                checks++;
                fails++;
                $display("FAIL R10 unexpected write: actual addr %0d data %0d expected none",
                         wr_addr, wr_data);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                check("R9", "wr_addr", int'(wr_addr), int'(e.addr));
                check("R9", "wr_data", int'(wr_data), int'(e.data));
                check("R6", "wr_bank", int'(wr_bank), int'(e.bank));
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check_cfg("R11", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        check("R11", "bp_count", int'(bp_count), 4);
        check("R11", "wr_en", int'(wr_en), 0);

        // R2/R3 mode set: 1_10_1_1_0_01 -> lp=1 en=1 bias=0 drive=01
        pulse_start();
        send_byte(8'hD9, 1'b0);
        check_cfg("R2", 1, 1, 0, 1, 0, 0, 0, 0, 0);
        check("R3", "bp_count static", int'(bp_count), 1);
        send_byte(8'hCE, 1'b0);              // lp=0 en=1 bias=1 drive=10
        check_cfg("R2", 0, 1, 1, 2, 0, 0, 0, 0, 0);
        check("R3", "bp_count 1:2", int'(bp_count), 2);
        send_byte(8'hCF, 1'b0);              // drive=11
        check("R3", "bp_count 1:3", int'(bp_count), 3);
        // R4 load pointer 22, last command
        send_byte(8'h16, 1'b0);
        m_ptr = 22;
        // R1 data phase: 0xA1 would be a pointer command, 0xC5 a mode set
        send_data(8'hA1);
        send_data(8'hC5);
        check_cfg("R12", 0, 1, 1, 3, 0, 0, 0, 0, 0);
        send_data(8'h3C);                    // R9 wraps 23 -> 0
        repeat (3) @(negedge clk);
        check("R12", "disp_en idle", int'(disp_en), 1);

        // Second transfer: first byte arrives together with the start strobe.
        send_byte(8'hE5, 1'b1);              // R5 device select 5
        m_sub = 5;
        check("R5", "dev_subaddr", int'(dev_subaddr), 5);
        send_byte(8'hFA, 1'b0);              // R6 in=1 out=0
        m_bank = 1'b1;
        check("R6", "bank_in_sel", int'(bank_in_sel), 1);
        check("R6", "bank_out_sel", int'(bank_out_sel), 0);
        send_byte(8'hF6, 1'b0);              // R7 alt=1 freq=2
        check("R7", "blink_alt", int'(blink_alt), 1);
        check("R7", "blink_freq", int'(blink_freq), 2);
        send_byte(8'hE8, 1'b0);              // R8 reserved 1101, continue
        send_byte(8'hFC, 1'b0);              // R8 reserved 11111, continue
        check_cfg("R8", 0, 1, 1, 3, 5, 1, 0, 1, 2);
        send_byte(8'h7F, 1'b0);              // R8 reserved, last command
        check_cfg("R8", 0, 1, 1, 3, 5, 1, 0, 1, 2);
        send_data(8'h55);                    // R10 hw=0 != 5: no write
        check("R10", "wr_en on mismatch", int'(wr_en), 0);
        check("R8", "blink_freq after data", int'(blink_freq), 2);
        hw_subaddr = 3'd5;
        send_data(8'h66);                    // R10 match: write at pointer 2
        check("R10", "wr_en on match", int'(wr_en), 1);

        // R1 a new transfer restarts the command phase; R4 modulo 24
        pulse_start();
        send_byte(8'h3F, 1'b0);
        m_ptr = 63 % NADDR;
        send_data(8'h77);
        send_data(8'h78);
        check("R1", "wr_en after restart", int'(wr_en), 1);

        repeat (4) @(negedge clk);
        check("R9", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule